// File: doc/BRIEF.md
# Acquisition Boost Sequencer for a Fractional PLL

This block controls the lock-acquisition boost of a fractional-N synthesizer. A write of the feedback divider word starts an acquisition interval. During that interval the charge pump runs with a separate, higher gain code. The phase-comparison rate can also be lowered by a programmable factor, which keeps the loop from slipping cycles. When the interval ends, the block returns to the steady-state gain code and to the full comparison rate. The block also drives one external pin. The pin either switches a helper resistor into the loop filter or serves as a general-purpose static output.

A 14-bit timeout word selects the mode. Values 0 to 3 are static pin modes: released, forced boost with the pin pulled low, steady low, and steady high. Values of 4 or more give a timed boost. This boost lasts twice the programmed value, counted in comparison cycles. The comparison cycle reaches the block as a single-cycle strobe. All outputs are registered. The block does not generate analog current.

Top module: `acq_boost_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become gain_act=0, cp_units=1, rate_div=1, pin_oe=0 and pin_out=0.
- R2: Timeout word 0 gives no boost: gain_act equals gain_steady, rate_div is 1 and pin_oe is 0.
- R3: Timeout word 1 forces boost permanently: gain_act equals gain_fast, the rate factor follows the CSR code, and the pin is driven low (pin_oe=1, pin_out=0).
- R4: Timeout words 2 and 3 give no boost and drive the pin statically, low for 2 and high for 3.
- R5: When the timeout word T is 4 or more, a cycle with n_wr high starts a boost. The boost stays on through exactly 2*T subsequent clock edges at which cmp_tick is high, and ends at the 2*T-th of those edges. While the boost is on, the pin is driven low. Once it ends, pin_oe returns to 0.
- R6: gain_act is gain_fast during a boost and gain_steady otherwise. cp_units always equals gain_act+1, the current in unit steps.
- R7: During a boost, rate_div is 1, 2, 4 or 16 for csr_code 0, 1, 2 or 3. Outside a boost it is 1.
- R8: An n_wr during an active boost reloads the interval to the full 2*T. If n_wr and cmp_tick arrive in the same cycle, the reload wins.
- R9: In timed mode, once the boost has ended, further cmp_tick pulses leave the outputs at steady-state values until the next n_wr.
- R10: Outputs change on the same clock edge that samples the causing input: one register stage.
- R11: When pin_oe is 0, pin_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_tick | input | 1 | One-cycle strobe per comparison cycle |
| n_wr | input | 1 | One-cycle strobe when the divider word is written |
| tmo_word | input | 14 | Timeout / pin-mode word |
| gain_steady | input | 4 | Steady-state charge-pump gain code |
| gain_fast | input | 4 | Boost charge-pump gain code |
| csr_code | input | 2 | Comparison-rate reduction code |
| gain_act | output | 4 | Active gain code |
| cp_units | output | 5 | Active current in unit steps (code+1) |
| rate_div | output | 5 | Active comparison-rate divisor (1, 2, 4, 16) |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions assume that configuration inputs (timeout word, gain codes, CSR code) are quasi-static. Each check compares an output with the input values sampled one edge earlier. They also assume that n_wr and cmp_tick are plain one-cycle strobes. The bench sets configuration only between edges and holds it for each measured interval. It pulses n_wr for a single cycle, except in the deliberate same-cycle collision case. Interval length is checked with tick-edge counts kept in the bench, never by looking inside the timer.

// File: rtl/acq_boost_pkg.sv
package acq_boost_pkg;
  typedef enum logic [1:0] {
    PM_RELEASE = 2'd0,
    PM_FORCE   = 2'd1,
    PM_LOW     = 2'd2,
    PM_HIGH    = 2'd3
  } pin_mode_e;

  localparam int RATE_W = 5;

  function automatic logic [RATE_W-1:0] rate_of(input logic [1:0] code);
    case (code)
      2'd0:    rate_of = RATE_W'(1);
      2'd1:    rate_of = RATE_W'(2);
      2'd2:    rate_of = RATE_W'(4);
      default: rate_of = RATE_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             busy_nxt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec && cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign busy_nxt = (cnt_d != '0);
endmodule

// File: rtl/acq_pin_mode.sv
module acq_pin_mode
  import acq_boost_pkg::*;
#(
  parameter int TMO_W = 14
) (
  input  logic [TMO_W-1:0] tmo_word,
  input  logic             busy,
  output logic             timed,
  output logic             boost,
  output logic             drv_oe,
  output logic             drv_val
);
  localparam int STATIC_LIM = 4;

  pin_mode_e mode;

  always_comb begin
    timed   = (tmo_word >= TMO_W'(STATIC_LIM));
    mode    = pin_mode_e'(tmo_word[1:0]);
    boost   = 1'b0;
    drv_oe  = 1'b0;
    drv_val = 1'b0;
    if (timed) begin
      boost  = busy;
      drv_oe = busy;
    end else begin
      case (mode)
        PM_RELEASE: drv_oe = 1'b0;
        PM_FORCE: begin
          boost  = 1'b1;
          drv_oe = 1'b1;
        end
        PM_LOW:  drv_oe = 1'b1;
        PM_HIGH: begin
          drv_oe  = 1'b1;
          drv_val = 1'b1;
        end
        default: drv_oe = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/acq_boost_ctrl.sv
module acq_boost_ctrl
  import acq_boost_pkg::*;
#(
  parameter int TMO_W  = 14,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_tick,
  input  logic              n_wr,
  input  logic [TMO_W-1:0]  tmo_word,
  input  logic [GAIN_W-1:0] gain_steady,
  input  logic [GAIN_W-1:0] gain_fast,
  input  logic [1:0]        csr_code,
  output logic [GAIN_W-1:0] gain_act,
  output logic [GAIN_W:0]   cp_units,
  output logic [4:0]        rate_div,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int CNT_W = TMO_W + 1;

  logic             timed, boost, drv_oe, drv_val, busy_nxt;
  logic [CNT_W-1:0] load_val;

  assign load_val = timed ? {tmo_word, 1'b0} : '0;

  acq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (n_wr),
    .load_val (load_val),
    .dec      (cmp_tick),
    .busy_nxt (busy_nxt)
  );

  acq_pin_mode #(.TMO_W(TMO_W)) u_mode (
    .tmo_word (tmo_word),
    .busy     (busy_nxt),
    .timed    (timed),
    .boost    (boost),
    .drv_oe   (drv_oe),
    .drv_val  (drv_val)
  );

  logic [GAIN_W-1:0] gain_sel;
  assign gain_sel = boost ? gain_fast : gain_steady;

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_act <= '0;
      cp_units <= (GAIN_W+1)'(1);
      rate_div <= 5'd1;
      pin_out  <= 1'b0;
      pin_oe   <= 1'b0;
    end else begin
      gain_act <= gain_sel;
      cp_units <= {1'b0, gain_sel} + (GAIN_W+1)'(1);
      rate_div <= boost ? rate_of(csr_code) : 5'd1;
      pin_out  <= drv_oe & drv_val;
      pin_oe   <= drv_oe;
    end
  end
endmodule

// File: rtl/acq_boost_chk.sv
module acq_boost_chk #(
  parameter int TMO_W  = 14,
  parameter int GAIN_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              n_wr,
  input logic [TMO_W-1:0]  tmo_word,
  input logic [GAIN_W-1:0] gain_fast,
  input logic [GAIN_W-1:0] gain_act,
  input logic [4:0]        rate_div,
  input logic              pin_out,
  input logic              pin_oe
);
  // R3
  manual_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmo_word) == TMO_W'(1)) |-> (gain_act == $past(gain_fast) && pin_oe && !pin_out));
  // R4
  static_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmo_word) == TMO_W'(3)) |-> (pin_oe && pin_out));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(n_wr) && $past(tmo_word) >= TMO_W'(4)) |-> (pin_oe && !pin_out));
  // R7
  rate_legal_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rate_div) == 1);
  // R7
  rate_only_boost_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rate_div != 5'd1) |-> (gain_act == $past(gain_fast)));
  // R11
  released_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);
endmodule

bind acq_boost_ctrl acq_boost_chk #(.TMO_W(TMO_W), .GAIN_W(GAIN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .n_wr     (n_wr),
  .tmo_word (tmo_word),
  .gain_fast(gain_fast),
  .gain_act (gain_act),
  .rate_div (rate_div),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/tb_acq_boost_ctrl.sv
module tb_acq_boost_ctrl;
  logic        clk = 1'b0;
  logic        rst, cmp_tick, n_wr;
  logic [13:0] tmo_word;
  logic [3:0]  gain_steady, gain_fast;
  logic [1:0]  csr_code;
  logic [3:0]  gain_act;
  logic [4:0]  cp_units, rate_div;
  logic        pin_out, pin_oe;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  acq_boost_ctrl dut (
    .clk(clk), .rst(rst), .cmp_tick(cmp_tick), .n_wr(n_wr),
    .tmo_word(tmo_word), .gain_steady(gain_steady), .gain_fast(gain_fast),
    .csr_code(csr_code), .gain_act(gain_act), .cp_units(cp_units),
    .rate_div(rate_div), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // fields: tmo[23:10] csr[9:8] oe[7] pin[6] boost[5] div[4:0]
  localparam logic [23:0] VEC [8] = '{
    {14'd0, 2'd2, 1'b0, 1'b0, 1'b0, 5'd1},
    {14'd1, 2'd0, 1'b1, 1'b0, 1'b1, 5'd1},
    {14'd1, 2'd1, 1'b1, 1'b0, 1'b1, 5'd2},
    {14'd1, 2'd2, 1'b1, 1'b0, 1'b1, 5'd4},
    {14'd1, 2'd3, 1'b1, 1'b0, 1'b1, 5'd16},
    {14'd2, 2'd3, 1'b1, 1'b0, 1'b0, 5'd1},
    {14'd3, 2'd1, 1'b1, 1'b1, 1'b0, 5'd1},
    {14'd5, 2'd3, 1'b0, 1'b0, 1'b0, 5'd1}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expects boost state at current outputs
  task automatic chk_state(input string req, input logic on, input logic [4:0] div);
    chk({req, " gain"}, 16'(gain_act), on ? 16'(gain_fast) : 16'(gain_steady));
    chk({req, " units"}, 16'(cp_units), on ? 16'(gain_fast) + 16'd1 : 16'(gain_steady) + 16'd1);
    chk({req, " div"}, 16'(rate_div), on ? 16'(div) : 16'd1);
    chk({req, " oe"}, 16'(pin_oe), 16'(on));
    chk({req, " pin"}, 16'(pin_out), 16'd0);
  endtask

  task automatic pulse_wr();
    n_wr = 1'b1; step(); n_wr = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cmp_tick = 1'b0; n_wr = 1'b0;
    tmo_word = 14'd1; gain_steady = 4'd3; gain_fast = 4'd12; csr_code = 2'd3;
    step(); step();
    // R1 reset values
    chk("R1 gain", 16'(gain_act), 16'd0);
    chk("R1 units", 16'(cp_units), 16'd1);
    chk("R1 div", 16'(rate_div), 16'd1);
    chk("R1 oe", 16'(pin_oe), 16'd0);
    chk("R1 pin", 16'(pin_out), 16'd0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R6 R7 R10 (one edge after input change)
    for (int i = 0; i < 8; i++) begin
      tmo_word = VEC[i][23:10];
      csr_code = VEC[i][9:8];
      cmp_tick = i[0];
      step();
      chk("R10 vec oe", 16'(pin_oe), 16'(VEC[i][7]));
      chk("R4 vec pin", 16'(pin_out), 16'(VEC[i][6]));
      chk("R6 vec gain", 16'(gain_act), VEC[i][5] ? 16'(gain_fast) : 16'(gain_steady));
      chk("R6 vec units", 16'(cp_units), (VEC[i][5] ? 16'(gain_fast) : 16'(gain_steady)) + 16'd1);
      chk("R7 vec div", 16'(rate_div), 16'(VEC[i][4:0]));
    end
    cmp_tick = 1'b0;

    // R5 timed boost T=4, tick every cycle -> ends at 8th tick
    tmo_word = 14'd4; csr_code = 2'd2;
    pulse_wr();
    chk_state("R5 start", 1'b1, 5'd4);
    cmp_tick = 1'b1;
    for (int k = 1; k < 8; k++) begin step(); chk_state("R5 running", 1'b1, 5'd4); end
    step(); chk_state("R5 expire", 1'b0, 5'd4);
    // R9 ticks after expiry do nothing
    for (int k = 0; k < 5; k++) step();
    chk_state("R9 idle", 1'b0, 5'd4);
    cmp_tick = 1'b0;

    // R5 sparse ticks: only edges with tick count
    tmo_word = 14'd4; csr_code = 2'd1;
    pulse_wr();
    for (int k = 1; k <= 8; k++) begin
      step(); chk_state("R5 sparse gap", 1'b1, 5'd2);
      cmp_tick = 1'b1; step(); cmp_tick = 1'b0;
      if (k < 8) chk_state("R5 sparse tick", 1'b1, 5'd2);
      else       chk_state("R5 sparse end", 1'b0, 5'd2);
    end

    // R8 reload mid-interval, with a simultaneous tick
    tmo_word = 14'd5; csr_code = 2'd3;
    pulse_wr();
    cmp_tick = 1'b1;
    for (int k = 0; k < 6; k++) step();
    n_wr = 1'b1; step(); n_wr = 1'b0;
    chk_state("R8 reload", 1'b1, 5'd16);
    for (int k = 1; k < 10; k++) begin step(); chk_state("R8 full length", 1'b1, 5'd16); end
    step(); chk_state("R8 end", 1'b0, 5'd16);
    cmp_tick = 1'b0;

    // R5 largest word: 32766 ticks
    tmo_word = 14'd16383; csr_code = 2'd0;
    pulse_wr();
    cmp_tick = 1'b1;
    for (int k = 1; k < 32766; k++) step();
    chk_state("R5 max last", 1'b1, 5'd1);
    step(); chk_state("R5 max end", 1'b0, 5'd1);
    cmp_tick = 1'b0;

    // R2 n_wr with word 0 leaves outputs steady, pin released (R11)
    tmo_word = 14'd0; pulse_wr();
    chk_state("R2 wr ignored", 1'b0, 5'd1);

    // R1 reset mid-boost
    tmo_word = 14'd6; pulse_wr();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 mid oe", 16'(pin_oe), 16'd0);
    chk("R1 mid gain", 16'(gain_act), 16'd0);
    step();
    chk_state("R1 timer cleared", 1'b0, 5'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule